// File: doc/BRIEF.md
# Special Message Unit for Tile Network Interface

This unit sits in a tile's network interface and carries two kinds of short, fixed-size message between tiles: a system message, which one piece of software uses to signal another, and a task-pointer message, which goes to a hardware task-assignment engine. To send, software sets a destination tile and a message class in a configuration register. It then writes a 32-bit payload. That write starts the send, and the unit injects the message into the network as one 64-bit flit.

On the receive side, the unit looks at the class bit of each ejected flit. A system message goes into a small FIFO, and an interrupt line stays high for as long as that FIFO holds anything. Software first reads the sender's tile number and then reads the payload, which removes the entry. A task-pointer message does not involve software. It is held in an output register and offered to the local accelerator over a valid/ready handshake. The ejection port is stalled until the accelerator takes it. No flit is ever dropped: a full FIFO or a pending task pointer stalls the network instead.

The send side runs a two-state machine. In TX_IDLE a payload write moves it to TX_SEND. In TX_SEND, tx_ready moves it back to TX_IDLE. The receive side also runs a two-state machine. In RX_OPEN a task-pointer flit moves it to RX_HANDOFF, and a system flit leaves it in RX_OPEN with one FIFO push. In RX_HANDOFF, tp_ready moves it back to RX_OPEN.

Register map (word address on `reg_addr`):
- 0 CFG (read/write): bits 7:0 destination tile, bit 8 class (0 system, 1 task pointer).
- 1 PAYLOAD (write): payload; the write starts a send.
- 2 RXDATA (read): payload of the oldest system message; the read removes it.
- 3 RXSRC (read): source tile of the oldest system message; the read does not remove it.
- 4 STATUS (read): bit 0 send busy, bit 1 receive FIFO not empty.

Top module: `smsg_unit`

## Requirements
- R1: After reset, tx_valid, tp_valid and irq are low, rx_ready is high, and STATUS reads 0.
- R2: A PAYLOAD write in TX_IDLE makes tx_valid high from the next cycle. The flit carries the CFG destination in bits 63:56, the unit's own tile number in bits 55:48, the class in bit 47 and the payload in bits 31:0. Bits 46:32 are zero.
- R3: While tx_valid is high and tx_ready is low, the flit stays unchanged and STATUS bit 0 reads 1. The cycle after tx_ready is seen, tx_valid is low.
- R4: A PAYLOAD write while busy has no effect: no second flit is sent and the pending flit keeps its payload.
- R5: An accepted flit with bit 47 = 0 enters the receive FIFO. irq is high from the next cycle, and stays high as long as the FIFO is not empty.
- R6: RXSRC returns bits 55:48 of the oldest entry. RXDATA returns its bits 31:0 and removes it. Entries come out in arrival order.
- R7: With 4 entries held, rx_ready is low for a system flit, and the flit is kept by the network. One RXDATA read makes rx_ready high again.
- R8: An accepted flit with bit 47 = 1 raises tp_valid from the next cycle, with tp_payload and tp_src taken from the flit. It does not touch irq or the FIFO.
- R9: While tp_valid is high, rx_ready is low and tp_payload stays unchanged until tp_ready. Task pointers reach the accelerator in arrival order.
- R10: An RXDATA read with the FIFO empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (needed for RXDATA removal) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | High while the system-message FIFO is not empty |
| tx_valid | output | 1 | Injection flit valid |
| tx_ready | input | 1 | Network accepts the injection flit |
| tx_flit | output | 64 | Injection flit |
| rx_valid | input | 1 | Ejection flit valid |
| rx_ready | output | 1 | Unit accepts the ejection flit |
| rx_flit | input | 64 | Ejection flit |
| tp_valid | output | 1 | Task pointer offered to the accelerator |
| tp_ready | input | 1 | Accelerator takes the task pointer |
| tp_src | output | 8 | Tile that sent the task pointer |
| tp_payload | output | 32 | Task pointer value |

## Verification
A FIFO pointer or count that goes wrong shows on the ports. irq would stay high after the last RXDATA read, or rx_ready would drop before four entries are held or stay high past four. Either shows in the cycle after the push or pop that broke the count. A send machine in the wrong state would drop tx_valid before tx_ready, or take a second payload while busy, and this shows at the injection port one cycle after the write. A receive machine left in RX_HANDOFF keeps rx_ready low after tp_ready, so the next flit is stalled from that cycle on.

// File: rtl/smsg_pkg.sv
package smsg_pkg;
    localparam int NODE_W  = 8;
    localparam int PAY_W   = 32;
    localparam int FLIT_W  = 64;
    localparam int ADDR_W  = 3;
    localparam int DEST_HI = FLIT_W - 1;
    localparam int SRC_HI  = FLIT_W - NODE_W - 1;
    localparam int CLS_BIT = FLIT_W - 2 * NODE_W - 1;

    typedef enum logic { CLS_SYS = 1'b0, CLS_TASK = 1'b1 } msg_cls_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG    = 3'd0,
        A_PAY    = 3'd1,
        A_RXDATA = 3'd2,
        A_RXSRC  = 3'd3,
        A_STATUS = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NODE_W-1:0] src;
        logic [PAY_W-1:0]  pay;
    } rx_entry_t;

    function automatic logic [FLIT_W-1:0] pack_flit(
        input logic [NODE_W-1:0] dest,
        input logic [NODE_W-1:0] src,
        input msg_cls_e          cls,
        input logic [PAY_W-1:0]  pay
    );
        logic [FLIT_W-1:0] f;
        f = '0;
        f[DEST_HI -: NODE_W] = dest;
        f[SRC_HI -: NODE_W]  = src;
        f[CLS_BIT]           = cls;
        f[PAY_W-1:0]         = pay;
        return f;
    endfunction
endpackage

// File: rtl/smsg_fifo.sv
module smsg_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/smsg_tx.sv
module smsg_tx
    import smsg_pkg::*;
#(
    parameter logic [NODE_W-1:0] MY_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [NODE_W-1:0] cfg_dest,
    input  msg_cls_e          cfg_cls,
    input  logic [PAY_W-1:0]  send_pay,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [FLIT_W-1:0] tx_flit,
    output logic              busy
);
    typedef enum logic { TX_IDLE, TX_SEND } tx_state_e;
    tx_state_e         state_q;
    logic [FLIT_W-1:0] flit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            flit_q  <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (send_req) begin
                    flit_q  <= pack_flit(cfg_dest, MY_ID, cfg_cls, send_pay);
                    state_q <= TX_SEND;
                end
                TX_SEND: if (tx_ready) state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_valid = (state_q == TX_SEND);
        busy     = (state_q == TX_SEND);
        tx_flit  = flit_q;
    end
endmodule

// File: rtl/smsg_rx.sv
module smsg_rx
    import smsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              rx_ready,
    input  logic              fifo_full,
    output logic              fifo_push,
    output rx_entry_t         fifo_din,
    output logic              tp_valid,
    input  logic              tp_ready,
    output logic [NODE_W-1:0] tp_src,
    output logic [PAY_W-1:0]  tp_payload
);
    typedef enum logic { RX_OPEN, RX_HANDOFF } rx_state_e;
    rx_state_e  state_q;
    rx_entry_t  hold_q;
    msg_cls_e   cls;
    logic       take;
    logic       unused_rx_bits;

    assign cls            = msg_cls_e'(rx_flit[CLS_BIT]);
    assign unused_rx_bits = ^{rx_flit[DEST_HI -: NODE_W], rx_flit[CLS_BIT-1:PAY_W]};
    assign take           = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_OPEN;
            hold_q  <= '0;
        end else begin
            unique case (state_q)
                RX_OPEN: if (take && cls == CLS_TASK) begin
                    hold_q  <= '{src: rx_flit[SRC_HI -: NODE_W], pay: rx_flit[PAY_W-1:0]};
                    state_q <= RX_HANDOFF;
                end
                RX_HANDOFF: if (tp_ready) state_q <= RX_OPEN;
            endcase
        end
    end

    always_comb begin
        rx_ready   = (state_q == RX_OPEN) && ((cls == CLS_TASK) || !fifo_full);
        fifo_push  = take && (cls == CLS_SYS);
        fifo_din   = '{src: rx_flit[SRC_HI -: NODE_W], pay: rx_flit[PAY_W-1:0]};
        tp_valid   = (state_q == RX_HANDOFF);
        tp_src     = hold_q.src;
        tp_payload = hold_q.pay;
    end
endmodule

// File: rtl/smsg_unit.sv
module smsg_unit
    import smsg_pkg::*;
#(
    parameter int                DEPTH = 4,
    parameter logic [NODE_W-1:0] MY_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PAY_W-1:0]  reg_wdata,
    output logic [PAY_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [FLIT_W-1:0] tx_flit,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              tp_valid,
    input  logic              tp_ready,
    output logic [NODE_W-1:0] tp_src,
    output logic [PAY_W-1:0]  tp_payload
);
    logic [NODE_W-1:0] cfg_dest_q;
    msg_cls_e          cfg_cls_q;
    logic              send_req, busy;
    logic              f_push, f_pop, f_empty, f_full;
    rx_entry_t         f_din, f_dout;

    assign send_req = reg_wr_en && (reg_addr == A_PAY);
    assign f_pop    = reg_rd_en && (reg_addr == A_RXDATA) && !f_empty;
    assign irq      = !f_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dest_q <= '0;
            cfg_cls_q  <= CLS_SYS;
        end else if (reg_wr_en && reg_addr == A_CFG) begin
            cfg_dest_q <= reg_wdata[NODE_W-1:0];
            cfg_cls_q  <= msg_cls_e'(reg_wdata[NODE_W]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG:    reg_rdata = PAY_W'({cfg_cls_q, cfg_dest_q});
            A_RXDATA: reg_rdata = f_empty ? '0 : f_dout.pay;
            A_RXSRC:  reg_rdata = f_empty ? '0 : PAY_W'(f_dout.src);
            A_STATUS: reg_rdata = PAY_W'({!f_empty, busy});
            default:  reg_rdata = '0;
        endcase
    end

    smsg_tx #(.MY_ID(MY_ID)) u_tx (
        .clk(clk), .rst_n(rst_n), .send_req(send_req),
        .cfg_dest(cfg_dest_q), .cfg_cls(cfg_cls_q), .send_pay(reg_wdata),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_flit(tx_flit), .busy(busy)
    );

    smsg_rx u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flit(rx_flit),
        .rx_ready(rx_ready), .fifo_full(f_full), .fifo_push(f_push),
        .fifo_din(f_din), .tp_valid(tp_valid), .tp_ready(tp_ready),
        .tp_src(tp_src), .tp_payload(tp_payload)
    );

    smsg_fifo #(.DEPTH(DEPTH), .W($bits(rx_entry_t))) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(f_push), .pop(f_pop),
        .din(f_din), .dout(f_dout), .empty(f_empty), .full(f_full)
    );
endmodule

// File: rtl/smsg_unit_chk.sv
module smsg_unit_chk
    import smsg_pkg::*;
#(
    parameter int                DEPTH = 4,
    parameter logic [NODE_W-1:0] MY_ID = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [FLIT_W-1:0] tx_flit,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [FLIT_W-1:0] rx_flit,
    input logic              tp_valid,
    input logic              tp_ready,
    input logic [PAY_W-1:0]  tp_payload
);
    localparam int CNT_W = $clog2(DEPTH + 2);
    logic [CNT_W-1:0] occ;
    logic             sys_in, sys_out;

    assign sys_in  = rx_valid && rx_ready && !rx_flit[CLS_BIT];
    assign sys_out = reg_rd_en && (reg_addr == A_RXDATA) && irq;

    always_ff @(posedge clk) begin
        if (!rst_n)                 occ <= '0;
        else if (sys_in && !sys_out) occ <= occ + 1'b1;
        else if (sys_out && !sys_in) occ <= occ - 1'b1;
    end

    a_r2_flit_fields: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_flit[SRC_HI -: NODE_W] == MY_ID) && (tx_flit[CLS_BIT-1:PAY_W] == '0));
    a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_flit));
    a_r5_irq_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (occ != '0));
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) && rx_valid && !rx_flit[CLS_BIT] |-> !rx_ready);
    a_r8_tp_raise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_flit[CLS_BIT] |=> tp_valid && (tp_payload == $past(rx_flit[PAY_W-1:0])));
    a_r9_tp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tp_valid && !tp_ready |=> tp_valid && $stable(tp_payload));
    a_r9_eject_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tp_valid |-> !rx_ready);
endmodule

bind smsg_unit smsg_unit_chk #(.DEPTH(DEPTH), .MY_ID(MY_ID)) u_chk (.*);

// File: tb/smsg_unit_tb.sv
module smsg_unit_tb;
    localparam logic [7:0] ME = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tx_valid, rx_ready, tp_valid;
    logic        tx_ready = 1'b0, rx_valid = 1'b0, tp_ready = 1'b0;
    logic [63:0] tx_flit;
    logic [63:0] rx_flit = '0;
    logic [7:0]  tp_src;
    logic [31:0] tp_payload;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    smsg_unit #(.DEPTH(4), .MY_ID(ME)) u_dut (.*);

    function automatic logic [63:0] mk(input logic [7:0] d, input logic [7:0] s,
                                       input logic c, input logic [31:0] p);
        return {d, s, c, 15'd0, p};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic push_rx(input logic [63:0] f);
        @(negedge clk);
        rx_valid = 1'b1; rx_flit = f;
        #1;
        while (!rx_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 tp_valid", tp_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_ready", rx_ready, 1);
        reg_read(3'd4, d);
        chk("R1 status", d, 0);
    endtask

    task automatic t_send();
        logic [31:0] d;
        tx_ready = 1'b0;
        reg_write(3'd0, 32'h0000_002A);
        reg_write(3'd1, 32'hDEAD_BEEF);
        #1 chk("R2 tx_valid", tx_valid, 1);
        chk("R2 flit", tx_flit, mk(8'h2A, ME, 1'b0, 32'hDEAD_BEEF));
        reg_read(3'd4, d);
        chk("R3 busy", d[0], 1);
        reg_write(3'd1, 32'h1111_1111);
        #1 chk("R4 flit kept", tx_flit, mk(8'h2A, ME, 1'b0, 32'hDEAD_BEEF));
        chk("R3 still valid", tx_valid, 1);
        tx_ready = 1'b1;
        @(negedge clk);
        #1 chk("R3 released", tx_valid, 0);
        repeat (2) @(negedge clk);
        #1 chk("R4 no second flit", tx_valid, 0);
        reg_write(3'd0, 32'h0000_0155);
        reg_write(3'd1, 32'h0BAD_F00D);
        #1 chk("R2 task flit", tx_flit, mk(8'h55, ME, 1'b1, 32'h0BAD_F00D));
        chk("R2 task valid", tx_valid, 1);
        @(negedge clk);
        #1 chk("R3 one-cycle send", tx_valid, 0);
        tx_ready = 1'b0;
    endtask

    task automatic t_sys_rx();
        logic [31:0] d;
        push_rx(mk(ME, 8'h21, 1'b0, 32'hAAAA_0001));
        #1 chk("R5 irq up", irq, 1);
        push_rx(mk(ME, 8'h22, 1'b0, 32'hAAAA_0002));
        reg_read(3'd3, d); chk("R6 src first", d, 32'h21);
        reg_read(3'd2, d); chk("R6 data first", d, 32'hAAAA_0001);
        #1 chk("R5 irq held", irq, 1);
        reg_read(3'd3, d); chk("R6 src second", d, 32'h22);
        reg_read(3'd2, d); chk("R6 data second", d, 32'hAAAA_0002);
        #1 chk("R5 irq down", irq, 0);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 1; i <= 4; i++) push_rx(mk(ME, 8'(i), 1'b0, 32'hB000_0000 + i));
        @(negedge clk);
        rx_valid = 1'b1; rx_flit = mk(ME, 8'd5, 1'b0, 32'hB000_0005);
        for (int k = 0; k < 3; k++) begin
            #1 chk("R7 full stall", rx_ready, 0);
            @(negedge clk);
        end
        reg_read(3'd2, d); chk("R7 pop while full", d, 32'hB000_0001);
        #1 chk("R7 ready after pop", rx_ready, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        for (int i = 2; i <= 5; i++) begin
            reg_read(3'd2, d);
            chk("R7 no drop order", d, 32'hB000_0000 + i);
        end
        #1 chk("R7 drained irq", irq, 0);
    endtask

    task automatic t_task();
        logic [31:0] d;
        tp_ready = 1'b0;
        push_rx(mk(ME, 8'h07, 1'b1, 32'hC0DE_0001));
        #1 chk("R8 tp_valid", tp_valid, 1);
        chk("R8 tp_payload", tp_payload, 32'hC0DE_0001);
        chk("R8 tp_src", tp_src, 8'h07);
        chk("R8 no irq", irq, 0);
        rx_valid = 1'b1; rx_flit = mk(ME, 8'h08, 1'b1, 32'hC0DE_0002);
        #1 chk("R9 stall", rx_ready, 0);
        repeat (2) @(negedge clk);
        #1 chk("R9 hold", tp_payload, 32'hC0DE_0001);
        chk("R9 still stalled", rx_ready, 0);
        tp_ready = 1'b1;
        @(negedge clk);
        tp_ready = 1'b0;
        #1 chk("R9 taken", tp_valid, 0);
        chk("R9 reopen", rx_ready, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        #1 chk("R9 second order", tp_payload, 32'hC0DE_0002);
        chk("R9 second valid", tp_valid, 1);
        tp_ready = 1'b1;
        @(negedge clk);
        tp_ready = 1'b0;
        #1 chk("R9 done", tp_valid, 0);
        reg_read(3'd2, d); chk("R8 fifo untouched", d, 0);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        reg_read(3'd2, d); chk("R10 empty read", d, 0);
        reg_read(3'd2, d); chk("R10 empty again", d, 0);
        #1 chk("R10 irq stays low", irq, 0);
        push_rx(mk(ME, 8'h33, 1'b0, 32'hD00D_0001));
        reg_read(3'd2, d); chk("R10 state intact", d, 32'hD00D_0001);
        #1 chk("R10 irq after", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_send();
        t_sys_rx();
        t_full();
        t_task();
        t_empty_read();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule